// File: doc/BRIEF.md
# Command-Sequence Write Guard

This block sits in front of a small nonvolatile array's write path and decides which write events may reach storage. It holds a persistent protect flag that comes up cleared. While the flag is clear, every accepted data write is passed to storage. While it is set, data writes are passed only if a fixed three-write unlock command came first within the same load window. A write that is not authorised is dropped, but it still causes a programming period to be started, so a host that polls for completion sees the same behaviour as for a real write.

Writes are grouped into load windows. An external inter-byte timer drives `win_active`, which is high while a window is open. When the window closes, the block issues a one-cycle `start_timer` pulse if the window held any write. Two command sequences are recognised. The three-step enable command turns protection on, and the six-step disable command turns it off. Neither command is stored. A command's change to the flag is held as pending and takes effect only when the external programming timer reports `prog_done`. Storage, the programming timer and data retention all lie outside this block.

Top module: `prot_seq_guard`

## Requirements
- R1: While reset is asserted, and on the cycle after it, `protect_on`, `commit_en` and `start_timer` are all 0.
- R2: With protection clear, a write that is not a command step and arrives with `win_active`=1 raises `commit_en` for exactly the following cycle.
- R3: With protection set and no unlock in the current window, a data write leaves `commit_en` at 0. The window still produces a single one-cycle `start_timer` pulse, in the cycle after the first cycle with `win_active`=0.
- R4: The enable command is three writes, in order: 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0xA0. Once it completes, `protect_on` goes to 1 only in the cycle after the next `prog_done`. Before that, `protect_on` does not change.
- R5: A write that matches the expected next step of a sequence is held as a command, and `commit_en` stays 0 for it.
- R6: With protection set, data writes that follow a completed command in the same window are committed. The unlock ends when that window closes.
- R7: The disable command is six writes, in order: 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x80, 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x20. It clears `protect_on` in the cycle after the next `prog_done`.
- R8: A write that breaks a sequence returns that sequence to its first step. The breaking write is judged as an ordinary data write, and the later steps of the broken sequence do not unlock.
- R9: If the window closes between two command steps, the partial sequence is discarded.
- R10: A write event with `win_active`=0 is ignored. It produces no commit and no `start_timer` pulse.
- R11: If `prog_done` falls in the same cycle as the last step of a new command, the earlier pending change is applied and the new command becomes the pending change.
- R12: After an unlock, a write whose address and data match a command step is stored as data.
- R13: A window that closes with no accepted write produces no `start_timer` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A write event is presented this cycle |
| wr_addr | input | 13 | Write address |
| wr_data | input | 8 | Write data |
| win_active | input | 1 | Load window is open |
| prog_done | input | 1 | One-cycle pulse: the external programming period has ended |
| commit_en | output | 1 | The previous cycle's write is to be stored |
| start_timer | output | 1 | One-cycle pulse: start a programming period |
| protect_on | output | 1 | Current protect flag |

## Verification
Two events can land in the same cycle. One is the final step of a command. The other is `prog_done`, which applies the change left pending by an earlier command. The bench provokes this by leaving a disable pending, then raising `prog_done` on the last write of an enable command. It then requires three things: protection drops at once, the data write that follows in the same window is committed, and a later `prog_done` turns protection back on. The bench also places a window close straight after a command that is only partly done, and requires the next step to be treated as plain data.

// File: rtl/prot_seq_guard_pkg.sv
// Package: default widths and command sequences for the write guard.
// Index 0 of each packed sequence array is the first step that is written.
package prot_seq_guard_pkg;
    localparam int unsigned GUARD_AW = 13;
    localparam int unsigned GUARD_DW = 8;
    localparam int unsigned ENA_LEN  = 3;
    localparam int unsigned DIS_LEN  = 6;

    localparam logic [ENA_LEN-1:0][GUARD_AW-1:0] DEF_ENA_ADDR =
        {13'h1555, 13'h0AAA, 13'h1555};
    localparam logic [ENA_LEN-1:0][GUARD_DW-1:0] DEF_ENA_DATA =
        {8'hA0, 8'h55, 8'hAA};
    localparam logic [DIS_LEN-1:0][GUARD_AW-1:0] DEF_DIS_ADDR =
        {13'h1555, 13'h0AAA, 13'h1555, 13'h1555, 13'h0AAA, 13'h1555};
    localparam logic [DIS_LEN-1:0][GUARD_DW-1:0] DEF_DIS_DATA =
        {8'h20, 8'h55, 8'hAA, 8'h80, 8'h55, 8'hAA};
endpackage

// File: rtl/prot_seq_track.sv
// Module: tracks progress through one fixed address/data command sequence.
// Assumes: step_vld is high only for writes that are eligible as command steps.
//          clr (window close) never coincides with step_vld.
// A step that matches advances the tracker. A step that does not match sends it
// back to step 0. The final step pulses done and also sends it back to step 0.
module prot_seq_track #(
    parameter int unsigned LEN = 3,
    parameter int unsigned AW  = 13,
    parameter int unsigned DW  = 8,
    parameter logic [LEN-1:0][AW-1:0] SEQ_ADDR = '0,
    parameter logic [LEN-1:0][DW-1:0] SEQ_DATA = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step_vld,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          hit,
    output logic          done
);
    localparam int unsigned SW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [SW-1:0] LAST = SW'(LEN - 1);

    logic [SW-1:0] step_q;

    // Compare the write against the step that is expected next.
    always_comb begin
        hit  = step_vld && (addr == SEQ_ADDR[step_q]) && (data == SEQ_DATA[step_q]);
        done = hit && (step_q == LAST);
    end

    // Step counter: advance on a match, return to step 0 on a mismatch, a completion or a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            step_q <= '0;
        end else if (step_vld) begin
            if (done || !hit) step_q <= '0;
            else              step_q <= step_q + 1'b1;
        end
    end
endmodule

// File: rtl/prot_seq_state.sv
// Module: the persistent protect flag and its pending change.
// Assumes: a completed command only records a pending change. The change is
// applied when the external programming period reports prog_done. A new command
// in the same cycle as prog_done becomes the next pending change.
module prot_seq_state (
    input  logic clk,
    input  logic rst_n,
    input  logic ena_req,
    input  logic dis_req,
    input  logic prog_done,
    output logic protect_on
);
    logic pend_q;
    logic pend_val_q;
    logic prot_q;

    // Pending register: record a new command, or drop the change once it has been applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_val_q <= 1'b0;
        end else if (ena_req || dis_req) begin
            pend_q     <= 1'b1;
            pend_val_q <= !dis_req;
        end else if (prog_done) begin
            pend_q     <= 1'b0;
        end
    end

    // Protect flag: takes the pending value at the end of a programming period.
    always_ff @(posedge clk) begin
        if (!rst_n)                  prot_q <= 1'b0;
        else if (prog_done && pend_q) prot_q <= pend_val_q;
    end

    assign protect_on = prot_q;
endmodule

// File: rtl/prot_seq_guard.sv
// Module: top of the command-sequence write guard.
// Assumes: win_active comes from an external inter-byte timer and is high while
// a load window is open. prog_done is a single-cycle pulse from the external
// programming timer. Outputs are registered: commit_en refers to the write
// presented in the previous cycle.
module prot_seq_guard #(
    parameter int unsigned AW      = prot_seq_guard_pkg::GUARD_AW,
    parameter int unsigned DW      = prot_seq_guard_pkg::GUARD_DW,
    parameter int unsigned ENA_LEN = prot_seq_guard_pkg::ENA_LEN,
    parameter int unsigned DIS_LEN = prot_seq_guard_pkg::DIS_LEN,
    parameter logic [ENA_LEN-1:0][AW-1:0] ENA_ADDR = prot_seq_guard_pkg::DEF_ENA_ADDR,
    parameter logic [ENA_LEN-1:0][DW-1:0] ENA_DATA = prot_seq_guard_pkg::DEF_ENA_DATA,
    parameter logic [DIS_LEN-1:0][AW-1:0] DIS_ADDR = prot_seq_guard_pkg::DEF_DIS_ADDR,
    parameter logic [DIS_LEN-1:0][DW-1:0] DIS_DATA = prot_seq_guard_pkg::DEF_DIS_DATA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          win_active,
    input  logic          prog_done,
    output logic          commit_en,
    output logic          start_timer,
    output logic          protect_on
);
    logic accept;
    logic trk_vld;
    logic closing;
    logic is_cmd;
    logic ena_hit, ena_done;
    logic dis_hit, dis_done;
    logic seen_q, unlock_q, commit_q, start_q;

    // Classify this cycle: an accepted write, a write eligible as a command step, a window close.
    always_comb begin
        accept  = wr_valid && win_active;
        trk_vld = accept && !unlock_q;
        closing = !win_active && seen_q;
        is_cmd  = ena_hit || dis_hit;
    end

    prot_seq_track #(
        .LEN(ENA_LEN), .AW(AW), .DW(DW), .SEQ_ADDR(ENA_ADDR), .SEQ_DATA(ENA_DATA)
    ) u_ena_trk (
        .clk(clk), .rst_n(rst_n), .clr(closing), .step_vld(trk_vld),
        .addr(wr_addr), .data(wr_data), .hit(ena_hit), .done(ena_done)
    );

    prot_seq_track #(
        .LEN(DIS_LEN), .AW(AW), .DW(DW), .SEQ_ADDR(DIS_ADDR), .SEQ_DATA(DIS_DATA)
    ) u_dis_trk (
        .clk(clk), .rst_n(rst_n), .clr(closing), .step_vld(trk_vld),
        .addr(wr_addr), .data(wr_data), .hit(dis_hit), .done(dis_done)
    );

    prot_seq_state u_state (
        .clk(clk), .rst_n(rst_n), .ena_req(ena_done), .dis_req(dis_done),
        .prog_done(prog_done), .protect_on(protect_on)
    );

    // Window bookkeeping: note writes seen, note an unlock, and clear both on close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            unlock_q <= 1'b0;
        end else if (closing) begin
            seen_q   <= 1'b0;
            unlock_q <= 1'b0;
        end else begin
            if (accept)              seen_q   <= 1'b1;
            if (ena_done || dis_done) unlock_q <= 1'b1;
        end
    end

    // Output registers: commit authorised data writes, pulse the timer on close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q <= 1'b0;
            start_q  <= 1'b0;
        end else begin
            commit_q <= accept && !is_cmd && (!protect_on || unlock_q);
            start_q  <= closing;
        end
    end

    assign commit_en   = commit_q;
    assign start_timer = start_q;
endmodule

// File: rtl/prot_seq_guard_chk.sv
// Module: assertion checker for prot_seq_guard, bound to every instance of it.
// Assumes: it sees only the top-level ports.
module prot_seq_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic win_active,
    input logic prog_done,
    input logic commit_en,
    input logic start_timer,
    input logic protect_on
);
    // R1: reset drives every output low.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (!protect_on && !commit_en && !start_timer));

    // R10: no commit unless a write arrived in an open window.
    p_ignore_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && win_active) |=> !commit_en);

    // R4: the protect flag changes only at the end of a programming period.
    p_protect_needs_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_done |=> $stable(protect_on));

    // R3: the timer request is a single-cycle pulse.
    p_timer_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_timer |=> !start_timer);

    // R13: a timer pulse follows a cycle in which the window was closed.
    p_timer_after_close_r13: assert property (@(posedge clk) disable iff (!rst_n)
        start_timer |-> $past(!win_active));

    // R2: a commit and a timer pulse never fall in the same cycle.
    p_commit_timer_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_en && start_timer));
endmodule

bind prot_seq_guard prot_seq_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .win_active(win_active),
    .prog_done(prog_done), .commit_en(commit_en), .start_timer(start_timer),
    .protect_on(protect_on)
);

// File: tb/prot_seq_guard_tb_top.sv
// Bench: a table of vectors walked by one loop, then directed tests.
module prot_seq_guard_tb_top;
    typedef struct packed {
        logic        wv;
        logic        win;
        logic        pd;
        logic [12:0] addr;
        logic [7:0]  data;
        logic        ec;
        logic        et;
        logic        ep;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 49;
    localparam vec_t VEC [0:NV-1] = '{
        // R2: plain write while protection is clear
        '{1'b1,1'b1,1'b0,13'h0010,8'h11,1'b1,1'b0,1'b0,4'd2},
        // R3: close produces one pulse, then none
        '{1'b0,1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b0,4'd3},
        '{1'b0,1'b0,1'b0,13'h0000,8'h00,1'b0,1'b0,1'b0,4'd3},
        // R10: write with the window closed is ignored
        '{1'b1,1'b0,1'b0,13'h0020,8'h22,1'b0,1'b0,1'b0,4'd10},
        '{1'b0,1'b0,1'b0,13'h0000,8'h00,1'b0,1'b0,1'b0,4'd10},
        // R5: enable command steps are not stored
        '{1'b1,1'b1,1'b0,13'h1555,8'hAA,1'b0,1'b0,1'b0,4'd5},
        '{1'b1,1'b1,1'b0,13'h0AAA,8'h55,1'b0,1'b0,1'b0,4'd5},
        '{1'b1,1'b1,1'b0,13'h1555,8'hA0,1'b0,1'b0,1'b0,4'd5},
        // R12: command-looking write after unlock is data
        '{1'b1,1'b1,1'b0,13'h1555,8'hAA,1'b1,1'b0,1'b0,4'd12},
        // R4: close, flag still clear; prog_done sets it
        '{1'b0,1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b0,4'd4},
        '{1'b0,1'b0,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b1,4'd4},
        // R3: protected write dropped, dummy timer still pulses
        '{1'b1,1'b1,1'b0,13'h0100,8'h33,1'b0,1'b0,1'b1,4'd3},
        '{1'b0,1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b1,4'd3},
        '{1'b0,1'b0,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b1,4'd4},
        // R6: unlock then page data committed
        '{1'b1,1'b1,1'b0,13'h1555,8'hAA,1'b0,1'b0,1'b1,4'd6},
        '{1'b1,1'b1,1'b0,13'h0AAA,8'h55,1'b0,1'b0,1'b1,4'd6},
        '{1'b1,1'b1,1'b0,13'h1555,8'hA0,1'b0,1'b0,1'b1,4'd6},
        '{1'b1,1'b1,1'b0,13'h0200,8'h44,1'b1,1'b0,1'b1,4'd6},
        '{1'b1,1'b1,1'b0,13'h0201,8'h45,1'b1,1'b0,1'b1,4'd6},
        '{1'b0,1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b1,4'd6},
        // R6: next window is locked again
        '{1'b1,1'b1,1'b0,13'h0202,8'h46,1'b0,1'b0,1'b1,4'd6},
        '{1'b0,1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b1,4'd6},
        '{1'b0,1'b0,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b1,4'd4},
        // R8: broken sequence, then the remaining step does not unlock
        '{1'b1,1'b1,1'b0,13'h1555,8'hAA,1'b0,1'b0,1'b1,4'd8},
        '{1'b1,1'b1,1'b0,13'h0AAA,8'h66,1'b0,1'b0,1'b1,4'd8},
        '{1'b1,1'b1,1'b0,13'h1555,8'hA0,1'b0,1'b0,1'b1,4'd8},
        '{1'b1,1'b1,1'b0,13'h0300,8'h77,1'b0,1'b0,1'b1,4'd8},
        '{1'b0,1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b1,4'd8},
        // R9: window closes mid-sequence
        '{1'b1,1'b1,1'b0,13'h1555,8'hAA,1'b0,1'b0,1'b1,4'd9},
        '{1'b1,1'b1,1'b0,13'h0AAA,8'h55,1'b0,1'b0,1'b1,4'd9},
        '{1'b0,1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b1,4'd9},
        '{1'b1,1'b1,1'b0,13'h1555,8'hA0,1'b0,1'b0,1'b1,4'd9},
        '{1'b1,1'b1,1'b0,13'h0301,8'h78,1'b0,1'b0,1'b1,4'd9},
        '{1'b0,1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b1,4'd9},
        // R7: six-step disable command
        '{1'b1,1'b1,1'b0,13'h1555,8'hAA,1'b0,1'b0,1'b1,4'd7},
        '{1'b1,1'b1,1'b0,13'h0AAA,8'h55,1'b0,1'b0,1'b1,4'd7},
        '{1'b1,1'b1,1'b0,13'h1555,8'h80,1'b0,1'b0,1'b1,4'd7},
        '{1'b1,1'b1,1'b0,13'h1555,8'hAA,1'b0,1'b0,1'b1,4'd7},
        '{1'b1,1'b1,1'b0,13'h0AAA,8'h55,1'b0,1'b0,1'b1,4'd7},
        '{1'b1,1'b1,1'b0,13'h1555,8'h20,1'b0,1'b0,1'b1,4'd7},
        '{1'b0,1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b1,4'd7},
        // R11: prog_done on the last enable step
        '{1'b1,1'b1,1'b0,13'h1555,8'hAA,1'b0,1'b0,1'b1,4'd11},
        '{1'b1,1'b1,1'b0,13'h0AAA,8'h55,1'b0,1'b0,1'b1,4'd11},
        '{1'b1,1'b1,1'b1,13'h1555,8'hA0,1'b0,1'b0,1'b0,4'd11},
        '{1'b1,1'b1,1'b0,13'h0400,8'h55,1'b1,1'b0,1'b0,4'd11},
        '{1'b0,1'b0,1'b0,13'h0000,8'h00,1'b0,1'b1,1'b0,4'd11},
        '{1'b0,1'b0,1'b1,13'h0000,8'h00,1'b0,1'b0,1'b1,4'd11},
        // R13: an empty window gives no pulse
        '{1'b0,1'b1,1'b0,13'h0000,8'h00,1'b0,1'b0,1'b1,4'd13},
        '{1'b0,1'b0,1'b0,13'h0000,8'h00,1'b0,1'b0,1'b1,4'd13}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        win_active = 1'b0;
    logic        prog_done = 1'b0;
    logic        commit_en, start_timer, protect_on;
    int          n_run = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    prot_seq_guard dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .win_active(win_active), .prog_done(prog_done),
        .commit_en(commit_en), .start_timer(start_timer), .protect_on(protect_on)
    );

    task automatic check(input string what, input int req, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic wv, input logic win, input logic pd,
                         input logic [12:0] a, input logic [7:0] d);
        wr_valid = wv; win_active = win; prog_done = pd; wr_addr = a; wr_data = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs low under reset
        check("reset commit", 1, commit_en, 1'b0);
        check("reset timer", 1, start_timer, 1'b0);
        check("reset protect", 1, protect_on, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].wv, VEC[i].win, VEC[i].pd, VEC[i].addr, VEC[i].data);
            @(negedge clk);
            check($sformatf("vec %0d commit", i), int'(VEC[i].req), commit_en, VEC[i].ec);
            check($sformatf("vec %0d timer", i), int'(VEC[i].req), start_timer, VEC[i].et);
            check($sformatf("vec %0d protect", i), int'(VEC[i].req), protect_on, VEC[i].ep);
        end
        // R1: reset in mid-run clears the set flag
        drive(1'b0, 1'b0, 1'b0, '0, '0);
        rst_n = 1'b0;
        @(negedge clk);
        check("mid reset protect", 1, protect_on, 1'b0);
        rst_n = 1'b1;
        // R8: with protection clear, the breaking write is stored as data
        drive(1'b1, 1'b1, 1'b0, 13'h1555, 8'hAA);
        @(negedge clk);
        check("first step held", 8, commit_en, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 13'h1555, 8'h12);
        @(negedge clk);
        check("breaking write stored", 8, commit_en, 1'b1);
        drive(1'b0, 1'b0, 1'b0, '0, '0);
        @(negedge clk);
        check("close after break", 3, start_timer, 1'b1);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule